// File: doc/BRIEF.md
# Long-Address Bus Cycle Sequencer

This block generates the memory bus cycles for the 24-bit absolute-long addressing mode of a 16-bit processor core. When the core starts an opcode, the block reads three operand bytes at the program counter within the current program bank. It joins them into a 24-bit effective address in a separate internal cycle. It then runs one or two data cycles, depending on the accumulator width chosen at start. Each clock carries at most one bus cycle, and read data is taken in the same cycle it is addressed.

A perform strobe goes to an external arithmetic stub, together with the latched opcode. For stores the strobe comes before the data cycles, and the stub's result fills the byte buffer that is written out. For loads the strobe comes after the data cycles and presents the assembled buffer. The long jump opcode uses the three operand bytes as a new program counter and program bank and runs no data cycles. Any opcode outside the supported set is refused with a one-cycle error pulse and produces no bus activity.

Top module: `long_addr_seq`

## Requirements
- R1: In the first three cycles after a start is accepted, the block issues reads (bus_valid_o=1, bus_we_o=0) at {pbr_i, pc_i}, {pbr_i, pc_i+1} and {pbr_i, pc_i+2}. The low 16 bits wrap and never carry into the bank byte.
- R2: The effective address is {third operand byte, second, first}. The fourth cycle has no bus cycle, and the first data cycle addresses the effective address.
- R3: Store (0x8F): the perform strobe comes in the fifth cycle. In 16-bit mode (m8_i=0 at start) op_result_i[7:0] is then written to the effective address and op_result_i[15:8] to the address plus one. In 8-bit mode only op_result_i[7:0] is written, to the effective address.
- R4: Loads (0x0F, 0x2F, 0x4F, 0x6F, 0xAF, 0xCF, 0xEF): in 16-bit mode the effective address and then the address plus one are read, and in 8-bit mode only the effective address. The perform strobe follows the last read, with op_data_o = {second byte, first byte} in 16-bit mode or {8'h00, byte} in 8-bit mode, and op_code_o = the opcode.
- R5: The increment to the second data address carries across all 24 bits, so 0x12FFFF is followed by 0x130000 and 0xFFFFFF by 0x000000.
- R6: Long jump (0x5C): the three operand reads, then one idle cycle, then a perform cycle with done_o. No data cycles. At done, pc_o = {second, first} and pbr_o = third byte.
- R7: The supported opcodes are exactly 0x5C and those whose low nibble is 0xF and whose bit 4 is 0. Only 0x8F drives bus_we_o.
- R8: A start with any other opcode gives err_o=1 in the following cycle, with no bus cycle, no perform strobe and no done. The block is idle again after that.
- R9: done_o is high for one cycle only, the last cycle of the sequence: cycle 5 for the jump, 6 for 8-bit loads and stores, 7 for 16-bit ones. The cycle after it is idle.
- R10: For loads and stores, pc_o = pc_i+2 (16-bit wrap) and pbr_o = pbr_i at done.
- R11: While a sequence runs, start_i, opcode_i and m8_i are ignored. The bus sequence stays as it was at start, and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| opcode_i | input | 8 | Opcode presented with start |
| m8_i | input | 1 | 1 selects 8-bit data width, 0 selects 16-bit |
| pc_i | input | 16 | Program counter at the first operand byte |
| pbr_i | input | 8 | Program bank |
| bus_valid_o | output | 1 | A bus cycle is issued this clock |
| bus_we_o | output | 1 | The bus cycle is a write |
| bus_addr_o | output | 24 | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, taken in the same cycle |
| perf_o | output | 1 | Perform strobe to the arithmetic stub |
| op_code_o | output | 8 | Opcode of the sequence in progress |
| op_data_o | output | 16 | Byte buffer presented at perform |
| op_result_i | input | 16 | Store data returned by the stub at perform |
| pc_o | output | 16 | Updated program counter, valid at done |
| pbr_o | output | 8 | Updated program bank, valid at done |
| done_o | output | 1 | Last cycle of an accepted sequence |
| err_o | output | 1 | Unsupported opcode was refused |

## Verification
The hardest cases to reach are the ones where an address overflows: a program counter of 0xFFFE whose bank fetch lands on 0x0000 in the same bank, and operand bytes 0xFF,0xFF whose 16-bit data increment must carry into the bank byte or wrap the whole 24-bit space. The bench sets the program counter and the operand bytes of its memory model to produce exactly these values, and runs every supported opcode in both widths against them. To reach the ignored-start case, the bench holds start_i high with an unsupported opcode and the opposite width for the whole of every other sequence. Any acceptance would then show up as an error pulse or as a changed data phase.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam int BYTE_W    = 8;
  localparam int N_ALU     = 8;
  localparam int ALU_IDX_W = $clog2(N_ALU);
  localparam logic [7:0] OPC_JUMP  = 8'h5C;
  localparam logic [7:0] OPC_STORE = 8'h8F;

  typedef enum logic [2:0] {
    S_IDLE, S_OPL, S_OPH, S_OPB, S_ADDR, S_PERF, S_DLO, S_DHI
  } state_e;

  typedef enum logic [1:0] {K_NONE, K_READ, K_WRITE, K_JUMP} kind_e;
endpackage

// File: rtl/lseq_decode.sv
module lseq_decode
  import lseq_pkg::*;
(
  input  logic [7:0] opcode_i,
  output kind_e      kind_o
);
  logic [N_ALU-1:0] alu_hit;

  // ALU long-mode opcodes: low nibble F, bit 4 clear, one per upper index
  for (genvar i = 0; i < N_ALU; i++) begin : g_alu
    assign alu_hit[i] = (opcode_i == {ALU_IDX_W'(i), 1'b0, 4'hF});
  end

  always_comb begin
    if (opcode_i == OPC_JUMP)       kind_o = K_JUMP;
    else if (opcode_i == OPC_STORE) kind_o = K_WRITE;
    else if (|alu_hit)              kind_o = K_READ;
    else                            kind_o = K_NONE;
  end
endmodule

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  kind_e  kind_i,
  input  logic   m8_i,
  output state_e state_o,
  output kind_e  kind_o,
  output logic   wide_o,
  output logic   accept_o,
  output logic   err_o,
  output logic   done_o,
  output logic   perf_o,
  output logic   bus_valid_o,
  output logic   bus_we_o
);
  state_e state_q, state_d;
  kind_e  kind_q;
  logic   wide_q, err_q;
  logic   idle;

  assign idle     = (state_q == S_IDLE);
  assign accept_o = start_i && idle && (kind_i != K_NONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept_o) state_d = S_OPL;
      S_OPL:  state_d = S_OPH;
      S_OPH:  state_d = S_OPB;
      S_OPB:  state_d = S_ADDR;
      S_ADDR: begin
        if (kind_q == K_READ) state_d = wide_q ? S_DLO : S_DHI;
        else                  state_d = S_PERF;
      end
      S_PERF: begin
        if (kind_q == K_WRITE) state_d = wide_q ? S_DLO : S_DHI;
        else                   state_d = S_IDLE;
      end
      S_DLO:  state_d = S_DHI;
      S_DHI:  state_d = (kind_q == K_WRITE) ? S_IDLE : S_PERF;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= start_i && idle && (kind_i == K_NONE);
      if (accept_o) begin
        kind_q <= kind_i;
        wide_q <= !m8_i;
      end
    end
  end

  assign state_o     = state_q;
  assign kind_o      = kind_q;
  assign wide_o      = wide_q;
  assign err_o       = err_q;
  assign perf_o      = (state_q == S_PERF);
  assign bus_valid_o = state_q inside {S_OPL, S_OPH, S_OPB, S_DLO, S_DHI};
  assign bus_we_o    = (kind_q == K_WRITE) && (state_q inside {S_DLO, S_DHI});
  assign done_o      = ((state_q == S_PERF) && (kind_q != K_WRITE)) ||
                       ((state_q == S_DHI) && (kind_q == K_WRITE));

  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (idle && !bus_valid_o && !perf_o && !done_o)); // R8
  AST_STORE_AFTER_PERF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && ((state_q == S_DLO) || !wide_q)) |-> $past(perf_o)); // R3
  AST_LOAD_BEFORE_PERF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perf_o && kind_q == K_READ) |-> ($past(state_q) == S_DHI && $past(bus_valid_o))); // R4
  AST_WE_STORE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (kind_q == K_WRITE)); // R7
  AST_JUMP_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == K_JUMP && !idle) |-> !(state_q inside {S_DLO, S_DHI})); // R6
  AST_DONE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (idle && !done_o)); // R9
  AST_END_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o})); // R9
endmodule

// File: rtl/lseq_dpath.sv
module lseq_dpath
  import lseq_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  state_e          state_i,
  input  kind_e           kind_i,
  input  logic            wide_i,
  input  logic            accept_i,
  input  logic [7:0]      opcode_i,
  input  logic [2*BW-1:0] pc_i,
  input  logic [BW-1:0]   pbr_i,
  input  logic [BW-1:0]   rdata_i,
  input  logic [2*BW-1:0] op_result_i,
  output logic [3*BW-1:0] bus_addr_o,
  output logic [BW-1:0]   bus_wdata_o,
  output logic [2*BW-1:0] pc_o,
  output logic [BW-1:0]   pbr_o,
  output logic [7:0]      op_code_o,
  output logic [2*BW-1:0] op_data_o
);
  localparam int PC_W   = 2 * BW;
  localparam int ADDR_W = 3 * BW;
  localparam int BUF_W  = 2 * BW;

  logic [PC_W-1:0]   pc_q;
  logic [BW-1:0]     pbr_q, lo_q, hi_q, bk_q;
  logic [ADDR_W-1:0] ea_q;
  logic [BUF_W-1:0]  buf_q;
  logic [7:0]        opc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      pbr_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      bk_q  <= '0;
      ea_q  <= '0;
      buf_q <= '0;
      opc_q <= '0;
    end else begin
      if (accept_i) begin
        pc_q  <= pc_i;
        pbr_q <= pbr_i;
        buf_q <= '0;
        opc_q <= opcode_i;
      end
      unique case (state_i)
        S_OPL: begin lo_q <= rdata_i; pc_q <= pc_q + 1'b1; end
        S_OPH: begin hi_q <= rdata_i; pc_q <= pc_q + 1'b1; end
        S_OPB: bk_q <= rdata_i;
        S_ADDR: begin
          ea_q <= {bk_q, hi_q, lo_q};
          if (kind_i == K_JUMP) begin
            pc_q  <= {hi_q, lo_q};
            pbr_q <= bk_q;
          end
        end
        S_PERF: if (kind_i == K_WRITE) buf_q <= op_result_i;
        S_DLO: begin
          if (kind_i == K_READ) buf_q[BW-1:0] <= rdata_i;
          ea_q <= ea_q + 1'b1;  // full-width carry into bank
        end
        S_DHI: begin
          if (kind_i == K_READ) begin
            if (wide_i) buf_q[BUF_W-1:BW] <= rdata_i;
            else        buf_q[BW-1:0]     <= rdata_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    if (state_i inside {S_OPL, S_OPH, S_OPB}) bus_addr_o = {pbr_q, pc_q};
    if (state_i inside {S_DLO, S_DHI})        bus_addr_o = ea_q;
    if (state_i == S_DLO) bus_wdata_o = buf_q[BW-1:0];
    if (state_i == S_DHI) bus_wdata_o = wide_i ? buf_q[BUF_W-1:BW] : buf_q[BW-1:0];
  end

  assign pc_o      = pc_q;
  assign pbr_o     = pbr_q;
  assign op_code_o = opc_q;
  assign op_data_o = buf_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {S_OPL, S_OPH}) |=> (pc_q == PC_W'($past(pc_q) + 1'b1)) && $stable(pbr_q)); // R1
  AST_BANK_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_OPB) |=> $stable(pc_q) && $stable(pbr_q)); // R1
  AST_EA_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_DLO) |=> (ea_q == ADDR_W'($past(ea_q) + 1'b1))); // R5
  AST_EA_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_ADDR) |=> (ea_q == {$past(bk_q), $past(hi_q), $past(lo_q)})); // R2
endmodule

// File: rtl/long_addr_seq.sv
module long_addr_seq
  import lseq_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [7:0]      opcode_i,
  input  logic            m8_i,
  input  logic [2*BW-1:0] pc_i,
  input  logic [BW-1:0]   pbr_i,
  output logic            bus_valid_o,
  output logic            bus_we_o,
  output logic [3*BW-1:0] bus_addr_o,
  output logic [BW-1:0]   bus_wdata_o,
  input  logic [BW-1:0]   bus_rdata_i,
  output logic            perf_o,
  output logic [7:0]      op_code_o,
  output logic [2*BW-1:0] op_data_o,
  input  logic [2*BW-1:0] op_result_i,
  output logic [2*BW-1:0] pc_o,
  output logic [BW-1:0]   pbr_o,
  output logic            done_o,
  output logic            err_o
);
  kind_e  dec_kind, run_kind;
  state_e state;
  logic   wide, accept;

  lseq_decode u_decode (
    .opcode_i (opcode_i),
    .kind_o   (dec_kind)
  );

  lseq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .kind_i      (dec_kind),
    .m8_i        (m8_i),
    .state_o     (state),
    .kind_o      (run_kind),
    .wide_o      (wide),
    .accept_o    (accept),
    .err_o       (err_o),
    .done_o      (done_o),
    .perf_o      (perf_o),
    .bus_valid_o (bus_valid_o),
    .bus_we_o    (bus_we_o)
  );

  lseq_dpath #(.BW(BW)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .kind_i      (run_kind),
    .wide_i      (wide),
    .accept_i    (accept),
    .opcode_i    (opcode_i),
    .pc_i        (pc_i),
    .pbr_i       (pbr_i),
    .rdata_i     (bus_rdata_i),
    .op_result_i (op_result_i),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .pc_o        (pc_o),
    .pbr_o       (pbr_o),
    .op_code_o   (op_code_o),
    .op_data_o   (op_data_o)
  );
endmodule

// File: tb/long_addr_seq_tb.sv
module long_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        m8 = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  pbr = '0;
  logic        bus_valid, bus_we;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        perf;
  logic [7:0]  op_code;
  logic [15:0] op_data;
  logic [15:0] op_result = '0;
  logic [15:0] pc_out;
  logic [7:0]  pbr_out;
  logic        done, err;

  int n_vec = 0;
  int n_bad = 0;

  // operand placement for the memory model
  logic [23:0] oa0 = '0, oa1 = '0, oa2 = '0;
  logic [7:0]  ob0 = '0, ob1 = '0, ob2 = '0;

  always #10 clk = ~clk;

  long_addr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode), .m8_i(m8),
    .pc_i(pc), .pbr_i(pbr), .bus_valid_o(bus_valid), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .perf_o(perf), .op_code_o(op_code), .op_data_o(op_data), .op_result_i(op_result),
    .pc_o(pc_out), .pbr_o(pbr_out), .done_o(done), .err_o(err)
  );

  function automatic logic [7:0] fill(logic [23:0] a);
    return (a[7:0] + 8'(a[15:8] * 3) + 8'(a[23:16] * 7)) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] mem(logic [23:0] a);
    if (a == oa2) return ob2;
    if (a == oa1) return ob1;
    if (a == oa0) return ob0;
    return fill(a);
  endfunction

  always_comb bus_rdata = mem(bus_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // runs one supported opcode; spam holds start with a refused opcode and flipped width
  task automatic run(input logic [7:0] opc, input bit narrow, input logic [15:0] pc0,
                     input logic [7:0] bank, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [7:0] bk, input logic [15:0] res, input bit spam);
    bit jmp = (opc == 8'h5C);
    bit wr  = (opc == 8'h8F);
    bit wide = !narrow;
    int n = jmp ? 5 : (wide ? 7 : 6);
    logic [23:0] ea = {bk, hi, lo};
    logic [23:0] ea1 = 24'(ea + 1);
    oa0 = {bank, pc0}; oa1 = {bank, 16'(pc0 + 1)}; oa2 = {bank, 16'(pc0 + 2)};
    ob0 = lo; ob1 = hi; ob2 = bk;
    op_result = res;
    opcode = opc; m8 = narrow; pc = pc0; pbr = bank; start = 1'b1;
    @(negedge clk);
    if (spam) begin opcode = 8'h00; m8 = !narrow; end
    else start = 1'b0;
    for (int c = 0; c < n; c++) begin
      bit ev = 0, ew = 0, ep = 0, ed = 0;
      logic [23:0] eadr = '0;
      logic [7:0]  ewd = '0;
      string tag;
      if (c < 3) begin ev = 1; eadr = {bank, 16'(pc0 + 16'(c))}; tag = "R1"; end
      else if (c == 3) tag = "R2";
      else if (jmp) begin ep = 1; ed = 1; tag = "R6"; end
      else if (wr) begin
        tag = "R3";
        if (c == 4) ep = 1;
        if (c == 5) begin ev = 1; ew = 1; eadr = ea; ewd = res[7:0]; ed = narrow; end
        if (c == 6) begin ev = 1; ew = 1; eadr = ea1; ewd = res[15:8]; ed = 1; tag = "R5"; end
      end else begin
        tag = "R4";
        if (c == 4) begin ev = 1; eadr = ea; if (c == 4) tag = "R2"; end
        if (c == 5 && wide) begin ev = 1; eadr = ea1; tag = "R5"; end
        if (c == n - 1) begin ep = 1; ed = 1; end
      end
      chk({bus_valid, bus_we, perf, done, err} == {ev, ew, ep, ed, 1'b0},
          {tag, "/R9/R11 ctl"}, {bus_valid, bus_we, perf, done, err}, {ev, ew, ep, ed, 1'b0});
      if (ev) chk(bus_addr == eadr, {tag, " addr"}, bus_addr, eadr);
      if (ew) chk(bus_wdata == ewd, {tag, " wdata"}, bus_wdata, ewd);
      if (ep) chk(op_code == opc, "R4 opcode", op_code, opc);
      if (ep && !jmp && !wr) begin
        logic [15:0] ex = wide ? {mem(ea1), mem(ea)} : {8'h00, mem(ea)};
        chk(op_data == ex, "R4 op_data", op_data, ex);
      end
      if (ed && jmp) begin
        chk(pc_out == {hi, lo}, "R6 pc", pc_out, {hi, lo});
        chk(pbr_out == bk, "R6 pbr", pbr_out, bk);
      end
      if (ed && !jmp) begin
        chk(pc_out == 16'(pc0 + 2), "R10 pc", pc_out, 16'(pc0 + 2));
        chk(pbr_out == bank, "R10 pbr", pbr_out, bank);
      end
      if (ed) start = 1'b0;
      @(negedge clk);
    end
    chk({bus_valid, done, err, perf} == 4'b0, "R9 idle after done", {bus_valid, done, err, perf}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] pcs [5]  = '{16'h1234, 16'hFFFE, 16'h0000, 16'h8001, 16'h4000};
    logic [7:0]  bks [5]  = '{8'h00,    8'h3C,    8'hFF,    8'h7F,    8'h55};
    logic [23:0] eas [5]  = '{24'h9A7856, 24'h12FFFF, 24'h000000, 24'hFFFFFE, 24'hFFFFFF};
    repeat (3) @(negedge clk);
    chk({bus_valid, bus_we, done, err, perf} == 5'b0, "R9 reset", {bus_valid, bus_we, done, err, perf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bus_valid, done, err, perf} == 4'b0, "R9 reset idle", {bus_valid, done, err, perf}, 0);
    for (int o = 0; o < 256; o++) begin
      logic [7:0] opc = 8'(o);
      bit ok = (opc[3:0] == 4'hF && !opc[4]) || opc == 8'h5C;
      if (ok) begin
        for (int p = 0; p < 5; p++) begin
          for (int w = 0; w < 2; w++) begin
            run(opc, w[0], pcs[p], bks[p], eas[p][7:0], eas[p][15:8], eas[p][23:16],
                16'hC3A0 ^ 16'(o * 257 + p), p[0]);
          end
        end
      end else begin
        // R7 R8: refused opcode
        opcode = opc; m8 = o[0]; pc = 16'h2000; pbr = 8'h01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err && !bus_valid && !perf && !done, "R8 reject", {err, bus_valid, perf, done}, 4'b1000);
        @(negedge clk);
        chk(!err && !bus_valid && !perf && !done, "R8 quiet", {err, bus_valid, perf, done}, 0);
      end
    end
    summary();
    $finish;
  end
endmodule